// File: doc/BRIEF.md
# Reset Supervisor with Edge-Serviced Watchdog

This block generates the system reset for a processor subsystem from three sources. The first is a supply-good flag driven by an external voltage comparator. The second is an active-low manual reset request. The third is a watchdog that software keeps alive by toggling a strobe line, in either direction. Once every source has gone quiet, the reset does not drop at once. It is held for a programmable release delay, so that clocks and memories can settle before the processor starts.

All timing runs on a slow time base. A prescaler divides the system clock into ticks (nominally one per millisecond). The release delay and the watchdog timeout are both counted in those ticks. Nominal settings are 200 ticks of delay with a 1600-tick timeout, or 25 and 200 ticks for a short variant.

When the watchdog expires, it raises a one-cycle request. That request is stretched by the same release delay into a reset pulse, and the watchdog starts a fresh full interval once the reset lifts. A strap input turns the watchdog off entirely, for boards that leave the strobe unconnected. The reset is offered in both polarities.

Top module: `rst_supervisor`

## Requirements
- R1: A low `supply_ok` asserts reset. `reset_n` goes low on the second rising clock edge after `supply_ok` falls, and it stays low for as long as `supply_ok` stays low.
- R2: When the last reset condition clears, `reset_n` stays low for the release delay and then rises. With P clocks per tick and D delay ticks, it rises no sooner than (D-1)*P cycles and no later than D*P+6 cycles after the condition clears at the port.
- R3: A low `mr_n` asserts reset through a two-stage synchronizer. `reset_n` is still high after the third rising edge and low after the fourth. When `mr_n` returns high, the R2 delay applies.
- R4: A rising edge and a falling edge on `wdi` each restart the watchdog. Edges spaced more closely than (T-1)*P cycles keep reset from asserting, even when edges of the same direction are further apart than that, where T is the number of timeout ticks.
- R5: While the watchdog is enabled, a gap with no `wdi` edge makes reset fall between (T-1)*P and T*P+8 cycles after the last edge or release. The resulting low pulse lasts between (D-1)*P and D*P+4 cycles.
- R6: After a watchdog reset ends, a new full timeout interval starts. With no edges, the next expiry falls within the R5 window, measured from the rise of `reset_n`.
- R7: While `wdi_enable` is low, the watchdog never expires and never asserts reset.
- R8: `reset` is always the exact inverse of `reset_n`.
- R9: A low `supply_ok` holds reset whatever the level of `mr_n`. Reset is inactive only when `supply_ok` is high and `mr_n` is high.
- R10: While reset is asserted, the watchdog counter is held clear and `wdi` edges are ignored. The timeout count starts only when `reset_n` rises.
- R11: The synchronous `rst` forces `reset_n` low and `reset` high. After `rst` is released, with the supply good and no manual request, `reset_n` rises after the R2 delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok | input | 1 | Comparator output; high when the supply is above threshold |
| mr_n | input | 1 | Asynchronous manual reset request, active low |
| wdi | input | 1 | Watchdog strobe; either edge services the watchdog |
| wdi_enable | input | 1 | Strap input; low disables the watchdog |
| reset_n | output | 1 | Registered system reset, active low |
| reset | output | 1 | Registered system reset, active high |

## Verification
The bench times every release against the tick-quantised window. This catches a delay counter that stops one tick short, and one that is not restarted when a new condition arrives. It services the watchdog with alternating edges spaced so that only one direction's edges would leave a gap past the timeout, which exposes a detector that responds to one edge direction only. It also toggles `wdi` while a manual reset is held, then measures the first timeout after release. A counter that was not held clear during reset expires early and fails that window. Edge-exact checks on when the reset asserts catch a synchronizer with the wrong depth. Random bursts of supply and manual faults, with random durations, confirm that the supply dominates and that the release delay is stretched from the last fault to clear.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic {
    HOLD_OFF = 1'b0,
    HOLD_ON  = 1'b1
  } hold_e;

  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= RESET_VAL;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= RESET_VAL;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rsup_tick.sv
module rsup_tick #(
  parameter int CLK_PER_TICK = 125000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  generate
    if (CLK_PER_TICK <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      localparam int PW = rsup_pkg::cnt_w(CLK_PER_TICK);
      logic [PW-1:0] div_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
          tick  <= 1'b0;
        end else if (div_q == PW'(CLK_PER_TICK - 1)) begin
          div_q <= '0;
          tick  <= 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
          tick  <= 1'b0;
        end
      end

      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R2
    end
  endgenerate

endmodule

// File: rtl/rsup_release.sv
module rsup_release
  import rsup_pkg::*;
#(
  parameter int DELAY_TICKS = 200
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  cond,
  output hold_e state
);

  localparam int DW = cnt_w(DELAY_TICKS);

  logic [DW-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= HOLD_ON;
      dly_q <= '0;
    end else if (cond) begin
      state <= HOLD_ON;
      dly_q <= '0;
    end else if (state == HOLD_ON && tick) begin
      if (dly_q == DW'(DELAY_TICKS - 1)) begin
        state <= HOLD_OFF;
        dly_q <= '0;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end
  end

  AST_COND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cond |=> (state == HOLD_ON));  // R1

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(state == HOLD_ON) |-> ($past(tick) && !$past(cond)));  // R2

endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
  parameter int TIMEOUT_TICKS = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic enable,
  input  logic strobe,
  output logic fire
);

  localparam int TW = rsup_pkg::cnt_w(TIMEOUT_TICKS);

  logic [TW-1:0] tmo_q;
  logic          strobe_prev_q;
  logic          edge_seen;

  assign edge_seen = strobe ^ strobe_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q         <= '0;
      strobe_prev_q <= 1'b0;
      fire          <= 1'b0;
    end else begin
      strobe_prev_q <= strobe;
      fire          <= 1'b0;
      if (hold || edge_seen) begin
        tmo_q <= '0;
      end else if (enable && tick) begin
        if (tmo_q == TW'(TIMEOUT_TICKS - 1)) begin
          tmo_q <= '0;
          fire  <= 1'b1;
        end else begin
          tmo_q <= tmo_q + 1'b1;
        end
      end
    end
  end

  AST_WD_HELD: assert property (@(posedge clk) disable iff (rst)
    hold |=> (tmo_q == '0));  // R10

  AST_WD_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (tmo_q == '0) && !fire);  // R4

  AST_WD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!enable && $past(!enable)) |-> !fire);  // R7

  AST_WD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);  // R6

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsup_pkg::*;
#(
  parameter int CLK_PER_TICK  = 125000,
  parameter int DELAY_TICKS   = 200,
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdi,
  input  logic wdi_enable,
  output logic reset_n,
  output logic reset
);

  logic [1:0] async_in;
  logic [1:0] sync_out;
  logic       mr_n_s;
  logic       wdi_s;
  logic       tick;
  logic       wd_fire;
  logic       cond;
  hold_e      hold_state;

  assign async_in = {wdi, mr_n};

  rsup_sync #(
    .WIDTH     (2),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (2'b01)
  ) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (sync_out)
  );

  assign mr_n_s = sync_out[0];
  assign wdi_s  = sync_out[1];

  rsup_tick #(
    .CLK_PER_TICK (CLK_PER_TICK)
  ) i_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rsup_watchdog #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) i_wdog (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hold   (hold_state == HOLD_ON),
    .enable (wdi_enable),
    .strobe (wdi_s),
    .fire   (wd_fire)
  );

  assign cond = !supply_ok || !mr_n_s || wd_fire;

  rsup_release #(
    .DELAY_TICKS (DELAY_TICKS)
  ) i_release (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .cond  (cond),
    .state (hold_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reset_n <= 1'b0;
      reset   <= 1'b1;
    end else begin
      reset_n <= (hold_state == HOLD_OFF);
      reset   <= (hold_state == HOLD_ON);
    end
  end

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    reset == !reset_n);  // R8

  AST_SUPPLY_OUT: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && $past(!supply_ok) && $past(!supply_ok, 2)) |-> !reset_n);  // R1

endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

  localparam int P = 4;
  localparam int D = 8;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic wdi = 1'b0;
  logic wdi_enable = 1'b0;
  logic reset_n;
  logic reset;

  int n_chk = 0;
  int n_bad = 0;
  int mism = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_supervisor #(
    .CLK_PER_TICK  (P),
    .DELAY_TICKS   (D),
    .TIMEOUT_TICKS (T),
    .SYNC_STAGES   (2)
  ) i_rst_supervisor (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .mr_n       (mr_n),
    .wdi        (wdi),
    .wdi_enable (wdi_enable),
    .reset_n    (reset_n),
    .reset      (reset)
  );

  always @(negedge clk) begin
    cyc++;
    if (!rst && (reset !== ~reset_n)) mism++;
  end

  function automatic int delay_lo();
    return (D - 1) * P;
  endfunction
  function automatic int delay_hi(input int slack);
    return D * P + slack;
  endfunction
  function automatic int tmo_lo();
    return (T - 1) * P;
  endfunction
  function automatic int tmo_hi(input int slack);
    return T * P + slack;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count negedges until reset_n equals val, up to lim.
  task automatic until_level(input logic val, input int lim, output int n);
    n = 0;
    while (reset_n !== val && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Hold for n cycles and report whether reset_n ever went low.
  task automatic watch_high(input int n, output bit dropped);
    dropped = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reset_n !== 1'b1) dropped = 1'b1;
    end
  endtask

  task automatic watch_low(input int n, output bit rose);
    rose = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reset_n !== 1'b0) rose = 1'b1;
    end
  endtask

  initial begin
    int n;
    bit flag;
    void'($urandom(32'd2417));

    // R11: reset state and power-on delay
    cycles(3);
    chk(reset_n === 1'b0, "R11 reset_n during rst", int'(reset_n), 0);
    chk(reset === 1'b1, "R11 reset during rst", int'(reset), 1);
    rst = 1'b0;
    until_level(1'b1, 200, n);
    chk_win("R11 power-on release", n, delay_lo(), delay_hi(4));
    cycles(5);

    // R1: supply fault timing and hold
    supply_ok = 1'b0;
    cycles(1);
    chk(reset_n === 1'b1, "R1 not before second edge", int'(reset_n), 1);
    cycles(1);
    chk(reset_n === 1'b0, "R1 asserted on second edge", int'(reset_n), 0);
    watch_low(60, flag);
    chk(!flag, "R1 held while supply low", int'(flag), 0);
    supply_ok = 1'b1;
    until_level(1'b1, 200, n);
    chk_win("R2 release after supply", n, delay_lo(), delay_hi(4));
    cycles(5);

    // R3: manual reset through synchronizer
    mr_n = 1'b0;
    cycles(3);
    chk(reset_n === 1'b1, "R3 still high after 3 edges", int'(reset_n), 1);
    cycles(1);
    chk(reset_n === 1'b0, "R3 low after 4 edges", int'(reset_n), 0);
    cycles(20);
    mr_n = 1'b1;
    until_level(1'b1, 200, n);
    chk_win("R3 release delay after mr_n", n, delay_lo(), delay_hi(6));
    cycles(5);

    // R9: supply dominates manual input
    supply_ok = 1'b0;
    mr_n = 1'b0;
    cycles(10);
    mr_n = 1'b1;
    watch_low(40, flag);
    chk(!flag, "R9 supply low with mr_n high", int'(flag), 0);
    supply_ok = 1'b1;
    mr_n = 1'b0;
    watch_low(40, flag);
    chk(!flag, "R9 mr_n low with supply good", int'(flag), 0);
    mr_n = 1'b1;
    until_level(1'b1, 200, n);
    chk(reset_n === 1'b1, "R9 inactive when both good", int'(reset_n), 1);
    cycles(5);

    // R7: watchdog disabled never expires
    wdi_enable = 1'b0;
    watch_high(3 * T * P, flag);
    chk(!flag, "R7 disabled watchdog silent", int'(flag), 0);

    // R5: expiry and pulse width
    wdi_enable = 1'b1;
    until_level(1'b0, 400, n);
    chk_win("R5 timeout to reset", n, tmo_lo(), tmo_hi(8));
    until_level(1'b1, 200, n);
    chk_win("R5 watchdog pulse width", n, delay_lo(), delay_hi(4));

    // R6: rearmed full interval
    until_level(1'b0, 400, n);
    chk_win("R6 rearmed interval", n, tmo_lo(), tmo_hi(4));
    until_level(1'b1, 200, n);

    // R4: alternating edges, each gap short, same-direction gap long
    cycles(2);
    for (int i = 0; i < 8; i++) begin
      wdi = ~wdi;
      watch_high(70, flag);
      if (flag) break;
    end
    chk(!flag, "R4 both edge directions service", int'(flag), 0);

    // R4: random service gaps
    flag = 1'b0;
    for (int i = 0; i < 20; i++) begin
      bit f;
      wdi = ~wdi;
      watch_high(int'($urandom_range(10, 60)), f);
      flag |= f;
    end
    chk(!flag, "R4 random servicing", int'(flag), 0);
    until_level(1'b0, 400, n);
    chk_win("R5 expiry after last edge", n, tmo_lo() - 60, tmo_hi(8));
    until_level(1'b1, 200, n);

    // R10: edges during reset are ignored, count starts at release
    cycles(2);
    mr_n = 1'b0;
    cycles(6);
    for (int i = 0; i < 5; i++) begin
      wdi = ~wdi;
      cycles(7);
    end
    mr_n = 1'b1;
    until_level(1'b1, 200, n);
    until_level(1'b0, 400, n);
    chk_win("R10 full interval after reset", n, tmo_lo(), tmo_hi(4));
    wdi_enable = 1'b0;
    until_level(1'b1, 200, n);
    cycles(3);

    // R2: random faults, release measured from last clearing source
    for (int i = 0; i < 10; i++) begin
      int sel = int'($urandom_range(0, 2));
      int len = int'($urandom_range(5, 40));
      int slack;
      if (sel == 0) supply_ok = 1'b0;
      else if (sel == 1) mr_n = 1'b0;
      else begin supply_ok = 1'b0; mr_n = 1'b0; end
      watch_low(len + 4, flag);
      if (sel == 2) begin
        supply_ok = 1'b1;
        cycles(int'($urandom_range(1, 10)));
      end
      slack = (sel == 0) ? 4 : 6;
      supply_ok = 1'b1;
      mr_n = 1'b1;
      until_level(1'b1, 200, n);
      chk_win("R2 random release", n, delay_lo(), delay_hi(slack));
      cycles(int'($urandom_range(2, 12)));
    end

    chk(mism == 0, "R8 complement mismatches", mism, 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 100000) @(negedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule